// File: doc/BRIEF.md
# Keypad Event Queue with Consuming and Peek Reads

This block buffers keypad press and release events for a host register interface. Each event arrives as a 7-bit key code and a press flag. The block packs the pair into one byte and appends it to a 16-entry circular queue. The host can drain the queue with a consuming read, or it can inspect any entry without side effects through an indexed peek. Key scanning and debouncing happen upstream.

The consuming read works in an unusual way. It moves the head forward first and then returns the entry at the new head. It also refuses to run while one entry or none is held, so the slot at the head is always the one consumed most recently. The peek counts its offset from that same head.

Storing an event sets a keypad bit in an interrupt status byte. A full queue turns the event into an overflow. The overflow is recorded in an error byte and flagged in the status byte. While both overflow marks stand, every new event is thrown away silently. An acknowledge input clears the status byte, and a flush input empties the queue. The interrupt output is active low.

Top module: `key_event_queue`

## Requirements
- R1: The queue holds 16 entries, and head, write position and peek position all wrap modulo 16, so steady traffic can run indefinitely without loss.
- R2: A stored entry carries the press flag in bit 7 and the key code in bits 6:0.
- R3: Every event that is stored sets bit 0 of the status byte (`int_status`).
- R4: An event that arrives when 16 entries are held is dropped. It sets bit 6 of `err_flags` and bit 3 of `int_status`.
- R5: While `int_status` bit 3 and `err_flags` bit 6 are both set, an arriving event changes nothing: no entry, no count change, no flag.
- R6: With one entry or none held, `pop_data` is 0x00 and a consuming read changes nothing. Otherwise `pop_data` is the entry at head+1, and the read advances the head by one and lowers the count by one.
- R7: `peek_data` is 0x00 when `peek_idx` is at least the count. Otherwise it is the entry at (head + `peek_idx`) mod 16. A peek never changes state.
- R8: `irq_n` is low exactly when `int_status` is nonzero.
- R9: `flush` sets head and count to zero within one cycle. It overrides an event and a consuming read in the same cycle, so neither has any effect.
- R10: An event and a consuming read in the same cycle both take effect, and the count changes by the net amount. The full test uses the count from before that cycle, so a full queue still overflows even while a read frees a slot.
- R11: `irq_ack` clears `int_status` and leaves `err_flags` alone. A flag set by an event in the same cycle survives the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue |
| ev_valid | input | 1 | Key event strobe |
| ev_code | input | 7 | Key code of the event |
| ev_press | input | 1 | 1 = press, 0 = release |
| pop_req | input | 1 | Consuming read strobe |
| pop_data | output | 8 | Byte a consuming read returns this cycle |
| peek_idx | input | 5 | Offset from head for the peek |
| peek_data | output | 8 | Byte at the peek offset |
| irq_ack | input | 1 | Clear the status byte |
| int_status | output | 8 | Status byte: bit 0 keypad, bit 3 error |
| err_flags | output | 8 | Error byte: bit 6 overflow (sticky) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest state to reach is the silent-discard window. To get there, the queue must first be filled to 16 entries and one more event must overflow it. That is not enough on its own, because a full queue would reject the next event even without the window. So the stimulus does one consuming read to open a free slot, and only then offers an event. With the slot free, the event could have been stored if the discard rule were broken. Peeking at offset 15 and checking the status byte then show that nothing was written. The stimulus also ends the window with an acknowledge and shows that the next event is stored again. An overflow with a read in the same cycle is driven from the full state to exercise the old-count rule.

// File: rtl/kq_pkg.sv
package kq_pkg;
   // Bit positions in the host-visible status and error bytes
   localparam int unsigned ST_KEY_BIT = 0;
   localparam int unsigned ST_ERR_BIT = 3;
   localparam int unsigned ER_OVF_BIT = 6;
   localparam int unsigned FLAG_W     = 8;

   typedef struct packed {
      logic accept;
      logic overflow;
   } kq_evt_t;
endpackage

// File: rtl/kq_store.sv
module kq_store #(
   parameter int unsigned DEPTH          = 16,
   parameter int unsigned DATA_W         = 8,
   parameter bit          CLEAR_ON_RESET = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [$clog2(DEPTH)-1:0]   wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [$clog2(DEPTH)-1:0]   rd_addr_a,
   output logic [DATA_W-1:0]          rd_data_a,
   input  logic [$clog2(DEPTH)-1:0]   rd_addr_b,
   output logic [DATA_W-1:0]          rd_data_b
);
   localparam int unsigned PTR_W = $clog2(DEPTH);

   logic [DATA_W-1:0] slot_q [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_slot
         logic hit;
         assign hit = wr_en && (wr_addr == PTR_W'(e));
         if (CLEAR_ON_RESET) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   slot_q[e] <= '0;
               else if (hit) slot_q[e] <= wr_data;
            end
         end else begin : g_nrst
            always_ff @(posedge clk) begin
               if (hit) slot_q[e] <= wr_data;
            end
         end
      end
   endgenerate

   assign rd_data_a = slot_q[rd_addr_a];
   assign rd_data_b = slot_q[rd_addr_b];

   // R2: the written byte is what the slot holds on the next cycle
   a_r2_stored_byte: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> slot_q[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/kq_ctrl.sv
module kq_ctrl #(
   parameter int unsigned DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push_ok,
   input  logic                       pop_req,
   output kq_pkg::kq_evt_t            evt,
   output logic                       wr_en,
   output logic [$clog2(DEPTH)-1:0]   wr_addr,
   output logic [$clog2(DEPTH)-1:0]   head,
   output logic [$clog2(DEPTH):0]     count,
   output logic                       pop_ok
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = PTR_W + 1;

   logic [PTR_W-1:0] head_q;
   logic [CNT_W-1:0] count_q;
   logic             full;

   assign full         = (count_q == CNT_W'(DEPTH));
   assign evt.accept   = push_ok && !flush && !full;
   assign evt.overflow = push_ok && !flush && full;
   assign pop_ok       = pop_req && !flush && (count_q > CNT_W'(1));
   assign wr_en        = evt.accept;
   assign wr_addr      = head_q + count_q[PTR_W-1:0];
   assign head         = head_q;
   assign count        = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         count_q <= '0;
      end else if (flush) begin
         head_q  <= '0;
         count_q <= '0;
      end else begin
         head_q  <= head_q + PTR_W'(pop_ok);
         count_q <= count_q + CNT_W'(evt.accept) - CNT_W'(pop_ok);
      end
   end

   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));

   a_r6_short_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !flush && count_q <= CNT_W'(1)) |=> head_q == $past(head_q));

   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count_q == '0) && (head_q == '0));

   a_r10_net_count: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.accept && pop_ok) |=> count_q == $past(count_q));
endmodule

// File: rtl/kq_flags.sv
module kq_flags (
   input  logic                         clk,
   input  logic                         rst_n,
   input  kq_pkg::kq_evt_t              evt,
   input  logic                         ack,
   output logic [kq_pkg::FLAG_W-1:0]    status,
   output logic [kq_pkg::FLAG_W-1:0]    errors,
   output logic                         blocked,
   output logic                         irq_n
);
   import kq_pkg::*;

   logic [FLAG_W-1:0] status_q, status_d;
   logic [FLAG_W-1:0] error_q;

   always_comb begin
      status_d = ack ? '0 : status_q;
      if (evt.accept)   status_d[ST_KEY_BIT] = 1'b1;
      if (evt.overflow) status_d[ST_ERR_BIT] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         error_q  <= '0;
      end else begin
         status_q <= status_d;
         if (evt.overflow) error_q[ER_OVF_BIT] <= 1'b1;
      end
   end

   assign status  = status_q;
   assign errors  = error_q;
   assign blocked = status_q[ST_ERR_BIT] && error_q[ER_OVF_BIT];
   assign irq_n   = ~|status_q;

   a_r4_overflow_marks: assert property (@(posedge clk) disable iff (!rst_n)
      evt.overflow |=> status_q[ST_ERR_BIT] && error_q[ER_OVF_BIT]);

   a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !evt.accept && !evt.overflow) |=> status_q == '0);

   a_r11_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(error_q[ER_OVF_BIT]) |-> error_q[ER_OVF_BIT]);
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue #(
   parameter int unsigned DEPTH          = 16,
   parameter int unsigned CODE_W         = 7,
   parameter bit          CLEAR_ON_RESET = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush,
   input  logic                    ev_valid,
   input  logic [CODE_W-1:0]       ev_code,
   input  logic                    ev_press,
   input  logic                    pop_req,
   output logic [CODE_W:0]         pop_data,
   input  logic [$clog2(DEPTH):0]  peek_idx,
   output logic [CODE_W:0]         peek_data,
   input  logic                    irq_ack,
   output logic [7:0]              int_status,
   output logic [7:0]              err_flags,
   output logic                    irq_n
);
   import kq_pkg::*;

   localparam int unsigned PTR_W  = $clog2(DEPTH);
   localparam int unsigned CNT_W  = PTR_W + 1;
   localparam int unsigned BYTE_W = CODE_W + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (CODE_W < 1) begin : g_bad_code
         $error("CODE_W must be at least 1");
      end
   endgenerate

   kq_evt_t            evt;
   logic               wr_en, pop_ok, blocked;
   logic [PTR_W-1:0]   wr_addr, head;
   logic [CNT_W-1:0]   count;
   logic [BYTE_W-1:0]  rd_a, rd_b;
   logic [PTR_W-1:0]   pop_addr, peek_addr;

   kq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .push_ok (ev_valid && !blocked),
      .pop_req (pop_req),
      .evt     (evt),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .head    (head),
      .count   (count),
      .pop_ok  (pop_ok)
   );

   assign pop_addr  = head + PTR_W'(1);
   assign peek_addr = head + peek_idx[PTR_W-1:0];

   kq_store #(.DEPTH(DEPTH), .DATA_W(BYTE_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   ({ev_press, ev_code}),
      .rd_addr_a (pop_addr),
      .rd_data_a (rd_a),
      .rd_addr_b (peek_addr),
      .rd_data_b (rd_b)
   );

   kq_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .ack     (irq_ack),
      .status  (int_status),
      .errors  (err_flags),
      .blocked (blocked),
      .irq_n   (irq_n)
   );

   assign pop_data  = (count > CNT_W'(1)) ? rd_a : '0;
   assign peek_data = (CNT_W'(peek_idx) < count) ? rd_b : '0;

   // R3 and R8: a stored event raises the interrupt on the next cycle
   a_r3_store_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      evt.accept |=> !irq_n && int_status[ST_KEY_BIT]);

   a_r5_blocked_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && blocked && !pop_req && !flush) |=> count == $past(count));

   a_r9_flush_beats_event: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && ev_valid) |-> !wr_en);

   a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (count <= CNT_W'(1)) |-> pop_data == '0);
endmodule

// File: tb/key_event_queue_tb_top.sv
module key_event_queue_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       flush = 1'b0, ev_valid = 1'b0, ev_press = 1'b0, pop_req = 1'b0, irq_ack = 1'b0;
   logic [6:0] ev_code = '0;
   logic [4:0] peek_idx = '0;
   logic [7:0] pop_data, peek_data, int_status, err_flags;
   logic       irq_n;

   int total = 0;
   int bad   = 0;

   // reference model
   logic [7:0] m_mem [16];
   int         m_head = 0;
   int         m_cnt  = 0;
   logic [7:0] m_stat = '0;
   logic [7:0] m_err  = '0;
   logic [7:0] exp_q [$];

   always #10 clk = ~clk;

   key_event_queue dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .ev_valid(ev_valid), .ev_code(ev_code),
      .ev_press(ev_press), .pop_req(pop_req), .pop_data(pop_data), .peek_idx(peek_idx),
      .peek_data(peek_data), .irq_ack(irq_ack), .int_status(int_status),
      .err_flags(err_flags), .irq_n(irq_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: compares each consuming read against the queued expectation
   always @(negedge clk) begin
      if (pop_req && rst_n) begin
         if (exp_q.size() == 0) chk("R6 unexpected read", 32'd1, 32'd0);
         else chk("R6 consuming read data", {24'd0, pop_data}, {24'd0, exp_q.pop_front()});
      end
   end

   function automatic logic [7:0] model_pop();
      return (m_cnt <= 1) ? 8'h00 : m_mem[(m_head + 1) % 16];
   endfunction

   function automatic void model_edge(input bit ev, input logic [6:0] code, input bit pr,
                                      input bit pop, input bit fl, input bit ack);
      bit blk, acc, ovf, dp;
      blk = m_stat[3] && m_err[6];
      acc = ev && !fl && !blk && (m_cnt < 16);
      ovf = ev && !fl && !blk && (m_cnt == 16);
      dp  = pop && !fl && (m_cnt > 1);
      if (acc) m_mem[(m_head + m_cnt) % 16] = {pr, code};
      if (fl) begin
         m_head = 0; m_cnt = 0;
      end else begin
         m_head = (m_head + int'(dp)) % 16;
         m_cnt  = m_cnt + int'(acc) - int'(dp);
      end
      if (ack) m_stat = '0;
      if (acc) m_stat[0] = 1'b1;
      if (ovf) begin m_stat[3] = 1'b1; m_err[6] = 1'b1; end
   endfunction

   // driver: one cycle of stimulus, expectation pushed before the edge
   task automatic step(input bit ev, input logic [6:0] code, input bit pr,
                       input bit pop, input bit fl, input bit ack);
      @(posedge clk); #1;
      ev_valid = ev; ev_code = code; ev_press = pr; pop_req = pop; flush = fl; irq_ack = ack;
      if (pop) exp_q.push_back(model_pop());
      @(posedge clk);
      model_edge(ev, code, pr, pop, fl, ack);
      #1;
      ev_valid = 0; pop_req = 0; flush = 0; irq_ack = 0;
   endtask

   task automatic push(input logic [6:0] code, input bit pr);
      step(1, code, pr, 0, 0, 0);
   endtask

   task automatic check_all(input string ctx);
      chk({"R3 status ", ctx}, {24'd0, int_status}, {24'd0, m_stat});
      chk({"R4 errors ", ctx}, {24'd0, err_flags}, {24'd0, m_err});
      chk({"R8 irq_n ", ctx}, {31'd0, irq_n}, {31'd0, (m_stat == 8'h00)});
      for (int i = 0; i <= 16; i++) begin
         peek_idx = 5'(i); #0.5;
         chk({"R7 peek ", ctx}, {24'd0, peek_data},
             {24'd0, (i < m_cnt) ? m_mem[(m_head + i) % 16] : 8'h00});
      end
   endtask

   initial begin
      #(20 * 100000);
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      check_all("reset");
      chk("R6 empty read data", {24'd0, pop_data}, 32'd0);
      step(0, 0, 0, 1, 0, 0);                 // read on empty queue
      check_all("empty read");

      // R2: press of code 0x3c stored as 0xbc
      push(7'h3c, 1);
      check_all("first event");
      peek_idx = 0; #0.5;
      chk("R2 packed press byte", {24'd0, peek_data}, 32'hbc);
      step(0, 0, 0, 1, 0, 0);                 // count 1: refused, returns 0
      check_all("single entry read refused");

      push(7'h11, 0);
      push(7'h22, 1);
      peek_idx = 1; #0.5;
      chk("R2 packed release byte", {24'd0, peek_data}, 32'h11);
      step(0, 0, 0, 1, 0, 0);                 // pre-increment read returns 0x11
      check_all("pre-increment read");

      step(0, 0, 0, 0, 0, 1);                 // R11 ack
      check_all("ack");
      chk("R11 irq released", {31'd0, irq_n}, 32'd1);

      // fill to 16, then overflow
      while (m_cnt < 16) push(7'(m_cnt + 8'h40), m_cnt[0]);
      check_all("full");
      push(7'h7f, 1);
      check_all("overflow");
      chk("R4 overflow bit", {24'd0, err_flags}, 32'h40);

      // R5: free one slot while blocked, event must vanish
      step(0, 0, 0, 1, 0, 0);
      push(7'h05, 1);
      peek_idx = 15; #0.5;
      chk("R5 blocked event not stored", {24'd0, peek_data}, 32'h00);
      chk("R5 no keypad flag change", {24'd0, int_status}, {24'd0, m_stat});
      check_all("blocked");

      // R11: ack ends the block, error stays sticky
      step(0, 0, 0, 0, 0, 1);
      chk("R11 error sticky", {24'd0, err_flags}, 32'h40);
      push(7'h06, 0);
      peek_idx = 15; #0.5;
      chk("R5 unblocked event stored", {24'd0, peek_data}, 32'h06);
      check_all("unblocked");

      // R10: full queue, event plus read in one cycle -> overflow and read
      step(1, 7'h33, 1, 1, 0, 0);
      chk("R10 full check uses old count", {24'd0, int_status}, 32'h09);
      check_all("full push+pop");
      step(0, 0, 0, 0, 0, 1);

      // R9: flush wins over event and read
      step(1, 7'h44, 1, 1, 1, 0);
      peek_idx = 0; #0.5;
      chk("R9 flush drops event", {24'd0, peek_data}, 32'h00);
      chk("R9 flush no keypad flag", {24'd0, int_status}, 32'h00);
      check_all("flush");

      // R10: concurrent event and read at count 3
      push(7'h01, 0); push(7'h02, 0); push(7'h03, 0);
      step(1, 7'h04, 1, 1, 0, 0);
      peek_idx = 2; #0.5;
      chk("R10 net count keeps 3 entries", {24'd0, peek_data}, 32'h84);
      peek_idx = 3; #0.5;
      chk("R10 no fourth entry", {24'd0, peek_data}, 32'h00);
      check_all("push+pop");

      // R11: ack with event in same cycle keeps keypad bit
      step(1, 7'h09, 0, 0, 0, 1);
      chk("R11 set beats clear", {24'd0, int_status}, 32'h01);
      check_all("ack+event");

      // R1: long wrap-around traffic
      for (int k = 0; k < 40; k++) begin
         step(1, 7'(k + 16), k[0], 1, 0, 0);
      end
      check_all("R1 wrap");
      for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 0, 0);
      check_all("R1 drain");

      repeat (2) @(posedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule